// File: doc/BRIEF.md
# Two-Wire Slave Register Port with Clock-Low Timeout

This block sits between the bit-level engine of a two-wire serial slave and the rest of a secure-memory device. The bit engine supplies byte strobes: one that loads the address pointer, one that writes a data byte, one that reads a data byte, and one for a STOP. The block maps these strobes onto a 256-byte address space. That space holds a 32-byte scratchpad, a write-only command register, a streaming MAC access port, per-page protection status bytes, a secret status byte and a read-only device ID.

The scratchpad accepts writes only in whole 4-byte groups. A transfer must begin at address 00h to reach it. A group left incomplete when the transfer ends is dropped. The command register takes a code byte and then a parameter byte, both written at 40h, and then hands the pair to the command engine as a single pulse. Address 41h passes MAC bytes to and from an external engine without advancing the pointer.

A watchdog counts clock cycles while the serial clock line is low. When the count expires, the block raises a STOP of its own, whatever the data line is doing.

Top module: `twi_reg_port`

## Requirements
- R1: After reset the pointer is 00h, the scratchpad is all zero, `rdata_o` is 00h and no pulse output is high. A read with no prior pointer load returns scratchpad byte 0.
- R2: After a pointer load of 00h, every fourth consecutive scratchpad write commits a 4-byte group to `scratch_o`. The byte at offset n appears at bits 8n+7..8n. Reads from a transfer that started at 00h return the stored bytes.
- R3: A STOP or a new pointer load discards a partly written group. Groups already committed are kept.
- R4: If the most recent pointer load was not 00h, scratchpad writes are ignored and scratchpad reads return FFh.
- R5: The first write at 40h captures the command code and leaves the pointer at 40h. The next write captures the parameter byte and advances the pointer to 41h. One cycle after the parameter write, `cmd_valid_o` pulses for one cycle with `cmd_code_o` and `cmd_param_o` valid.
- R6: At 41h the pointer does not advance. A read asserts `mac_rd_o` in the strobe cycle and returns `mac_rdata_i`. A write asserts `mac_wr_o` with `mac_wdata_o` equal to the written byte.
- R7: A read at 50h+p returns protection byte p, taken from `prot_i` bits 8p+7..8p. A read at 60h returns `secret_i`.
- R8: Reads at 68h+k return ID byte k, least significant byte first, taken from `id_i` bits 8k+7..8k.
- R9: Writes to read-only or unmapped addresses change no state and produce no pulse. Reads of 40h or of unmapped addresses return FFh.
- R10: Outside the cases in R5 and R6, the pointer increments by one after every byte read or byte write.
- R11: When `scl_i` has been low for TIMEOUT_CYC consecutive cycles, `timeout_o` pulses for one cycle. A high level on `scl_i` restarts the count. No second pulse occurs until `scl_i` has risen again.
- R12: `bus_stop_o` is high whenever `stop_i` or `timeout_o` is high. The timeout has the same effect as a STOP: it discards a partial group and a pending command code, and it removes scratchpad access until the next load of 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock level |
| stop_i | input | 1 | STOP seen by the bit engine |
| addr_ld_i | input | 1 | Load the pointer from addr_i |
| addr_i | input | 8 | New pointer value |
| wr_i | input | 1 | Byte write strobe |
| wdata_i | input | 8 | Write byte |
| rd_i | input | 1 | Byte read strobe |
| rdata_o | output | 8 | Read byte, valid the cycle after rd_i |
| prot_i | input | N_PAGES*8 | Protection byte per page |
| secret_i | input | 8 | Secret status byte |
| id_i | input | ID_BYTES*8 | Device ID, byte 0 in the low bits |
| mac_rdata_i | input | 8 | Next MAC byte from the engine |
| mac_rd_o | output | 1 | MAC byte consumed |
| mac_wr_o | output | 1 | MAC byte delivered |
| mac_wdata_o | output | 8 | Delivered MAC byte |
| cmd_valid_o | output | 1 | Command pair ready |
| cmd_code_o | output | 8 | Command code |
| cmd_param_o | output | 8 | Command parameter |
| scratch_o | output | SCR_BYTES*8 | Committed scratchpad contents |
| timeout_o | output | 1 | Clock-low timeout pulse |
| bus_stop_o | output | 1 | Effective STOP |

## Verification
The bound checker tests several rules on every cycle:
- the pointer holds at 41h and steps by one after other reads;
- the timeout pulse lasts one cycle, follows a low clock, and always appears as a STOP;
- a command pulse is always preceded by a write at 40h;
- the scratchpad changes only after a write into its range, and never after a write to the read-only window.

Other behaviour spans a whole transfer and is left to the bench scenarios: grouping into 4-byte commits, dropping a partial group at STOP or at the timeout, the start-at-00h rule, the code/parameter pairing, the LSB-first ID order, and the exact expiry cycle of the timeout.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] CMD_ADDR  = 8'h40;
  localparam logic [7:0] MAC_ADDR  = 8'h41;
  localparam logic [7:0] PROT_BASE = 8'h50;
  localparam logic [7:0] SEC_ADDR  = 8'h60;
  localparam logic [7:0] ID_BASE   = 8'h68;
  localparam logic [7:0] NO_DATA   = 8'hFF;

  typedef enum logic [2:0] {
    RG_SCR, RG_CMD, RG_MAC, RG_PROT, RG_SEC, RG_ID, RG_NONE
  } region_e;

  function automatic region_e region_of(input logic [7:0] a, input int unsigned scr_bytes,
                                        input int unsigned n_pages, input int unsigned id_bytes);
    if (32'(a) < scr_bytes) return RG_SCR;
    if (a == CMD_ADDR) return RG_CMD;
    if (a == MAC_ADDR) return RG_MAC;
    if (a >= PROT_BASE && 32'(a) < 32'(PROT_BASE) + n_pages) return RG_PROT;
    if (a == SEC_ADDR) return RG_SEC;
    if (a >= ID_BASE && 32'(a) < 32'(ID_BASE) + id_bytes) return RG_ID;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/twi_scl_watchdog.sv
module twi_scl_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expire_q;

  // saturate at the limit so one low phase yields a single pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (scl_i) begin
        cnt_q <= '0;
      end else if (cnt_q != CNT_W'(TIMEOUT_CYC)) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) expire_q <= 1'b1;
      end
    end
  end

  assign expire_o = expire_q;
endmodule

// File: rtl/twi_scratch_buf.sv
module twi_scratch_buf #(
  parameter int unsigned SCR_BYTES = 32,
  parameter int unsigned GRP_BYTES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [$clog2(SCR_BYTES)-1:0] off_i,
  input  logic [7:0]               wdata_i,
  input  logic                     flush_i,
  output logic [SCR_BYTES*8-1:0]   mem_o
);
  localparam int unsigned OFF_W = $clog2(SCR_BYTES);
  localparam int unsigned LANE_W = $clog2(GRP_BYTES);
  localparam int unsigned N_GRP = SCR_BYTES / GRP_BYTES;

  logic [GRP_BYTES-2:0][7:0] stage_q;
  logic [GRP_BYTES-2:0]      mask_q;
  logic [LANE_W-1:0]         lane;
  logic [OFF_W-LANE_W-1:0]   grp;
  logic                      last_lane, commit;

  assign lane      = off_i[LANE_W-1:0];
  assign grp       = off_i[OFF_W-1:LANE_W];
  assign last_lane = (lane == LANE_W'(GRP_BYTES - 1));
  assign commit    = wr_i && last_lane && (&mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      mask_q  <= '0;
    end else if (flush_i) begin
      mask_q <= '0;
    end else if (wr_i) begin
      if (last_lane) begin
        mask_q <= '0;
      end else begin
        stage_q[lane] <= wdata_i;
        mask_q[lane]  <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [GRP_BYTES*8-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (commit && grp == (OFF_W-LANE_W)'(g)) word_q <= {wdata_i, stage_q};
    end
    assign mem_o[g*GRP_BYTES*8 +: GRP_BYTES*8] = word_q;
  end
endmodule

// File: rtl/twi_reg_port.sv
module twi_reg_port
  import twi_reg_pkg::*;
#(
  parameter int unsigned N_PAGES     = 16,
  parameter int unsigned ID_BYTES    = 8,
  parameter int unsigned SCR_BYTES   = 32,
  parameter int unsigned GRP_BYTES   = 4,
  parameter int unsigned TIMEOUT_CYC = 10_000_000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   stop_i,
  input  logic                   addr_ld_i,
  input  logic [7:0]             addr_i,
  input  logic                   wr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   rd_i,
  output logic [7:0]             rdata_o,
  input  logic [N_PAGES*8-1:0]   prot_i,
  input  logic [7:0]             secret_i,
  input  logic [ID_BYTES*8-1:0]  id_i,
  input  logic [7:0]             mac_rdata_i,
  output logic                   mac_rd_o,
  output logic                   mac_wr_o,
  output logic [7:0]             mac_wdata_o,
  output logic                   cmd_valid_o,
  output logic [7:0]             cmd_code_o,
  output logic [7:0]             cmd_param_o,
  output logic [SCR_BYTES*8-1:0] scratch_o,
  output logic                   timeout_o,
  output logic                   bus_stop_o
);
  localparam int unsigned SO_W = $clog2(SCR_BYTES);
  localparam int unsigned PG_W = $clog2(N_PAGES);
  localparam int unsigned ID_W = $clog2(ID_BYTES);

  logic [7:0] ptr_q, rdata_q, code_q, param_q, rd_mux;
  logic       scr_ok_q, cmd_pend_q, cmd_valid_q, expire;
  region_e    region;
  logic       scr_wr, cmd_hit, hold_ptr, flush;

  logic [7:0] prot_b [N_PAGES];
  logic [7:0] id_b   [ID_BYTES];
  logic [7:0] scr_b  [SCR_BYTES];

  for (genvar p = 0; p < N_PAGES; p++) begin : g_prot
    assign prot_b[p] = prot_i[p*8 +: 8];
  end
  for (genvar k = 0; k < ID_BYTES; k++) begin : g_id
    assign id_b[k] = id_i[k*8 +: 8];
  end
  for (genvar s = 0; s < SCR_BYTES; s++) begin : g_scr
    assign scr_b[s] = scratch_o[s*8 +: 8];
  end

  twi_scl_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .expire_o(expire)
  );

  assign timeout_o  = expire;
  assign bus_stop_o = stop_i | expire;
  assign flush      = bus_stop_o | addr_ld_i;

  assign region   = region_of(ptr_q, SCR_BYTES, N_PAGES, ID_BYTES);
  assign scr_wr   = wr_i && !flush && region == RG_SCR && scr_ok_q;
  assign cmd_hit  = wr_i && !flush && region == RG_CMD;
  assign mac_rd_o = rd_i && region == RG_MAC;
  assign mac_wr_o = wr_i && region == RG_MAC;
  assign mac_wdata_o = wdata_i;
  // pointer parks on the MAC port and on the command code byte
  assign hold_ptr = (region == RG_MAC) || (cmd_hit && !cmd_pend_q);

  twi_scratch_buf #(.SCR_BYTES(SCR_BYTES), .GRP_BYTES(GRP_BYTES)) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (scr_wr),
    .off_i  (ptr_q[SO_W-1:0]),
    .wdata_i(wdata_i),
    .flush_i(flush),
    .mem_o  (scratch_o)
  );

  always_comb begin
    unique case (region)
      RG_SCR:  rd_mux = scr_ok_q ? scr_b[ptr_q[SO_W-1:0]] : NO_DATA;
      RG_MAC:  rd_mux = mac_rdata_i;
      RG_PROT: rd_mux = prot_b[PG_W'(ptr_q - PROT_BASE)];
      RG_SEC:  rd_mux = secret_i;
      RG_ID:   rd_mux = id_b[ID_W'(ptr_q - ID_BASE)];
      default: rd_mux = NO_DATA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      scr_ok_q <= 1'b1;
      rdata_q  <= '0;
    end else begin
      if (rd_i) rdata_q <= rd_mux;
      if (addr_ld_i) begin
        ptr_q    <= addr_i;
        scr_ok_q <= (addr_i == 8'h00);
      end else begin
        if (bus_stop_o) scr_ok_q <= 1'b0;
        if ((wr_i || rd_i) && !hold_ptr) ptr_q <= ptr_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_pend_q  <= 1'b0;
      cmd_valid_q <= 1'b0;
      code_q      <= '0;
      param_q     <= '0;
    end else begin
      cmd_valid_q <= 1'b0;
      if (flush) begin
        cmd_pend_q <= 1'b0;
      end else if (cmd_hit) begin
        if (!cmd_pend_q) begin
          code_q     <= wdata_i;
          cmd_pend_q <= 1'b1;
        end else begin
          param_q     <= wdata_i;
          cmd_pend_q  <= 1'b0;
          cmd_valid_q <= 1'b1;
        end
      end
    end
  end

  assign rdata_o     = rdata_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_code_o  = code_q;
  assign cmd_param_o = param_q;
endmodule

// File: rtl/twi_reg_port_chk.sv
module twi_reg_port_chk #(
  parameter int unsigned SCR_BYTES = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   scl_i,
  input logic                   addr_ld_i,
  input logic                   wr_i,
  input logic                   rd_i,
  input logic [7:0]             ptr_q,
  input logic                   timeout_o,
  input logic                   bus_stop_o,
  input logic                   cmd_valid_o,
  input logic [SCR_BYTES*8-1:0] scratch_o
);
  AST_MAC_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) && !addr_ld_i && ptr_q == 8'h41 |=> ptr_q == 8'h41); // R6
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && !addr_ld_i && ptr_q != 8'h41 |=> ptr_q == $past(ptr_q) + 8'd1); // R10
  AST_TO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R11
  AST_TO_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !$past(scl_i)); // R11
  AST_TO_IS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> bus_stop_o); // R12
  AST_CMD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(wr_i && ptr_q == 8'h40)); // R5
  AST_SCR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scratch_o) |-> $past(wr_i && 32'(ptr_q) < SCR_BYTES)); // R2
  AST_RO_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && ptr_q >= 8'h50 && ptr_q < 8'h70 |=> $stable(scratch_o) && !cmd_valid_o); // R9
endmodule

bind twi_reg_port twi_reg_port_chk #(.SCR_BYTES(SCR_BYTES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .addr_ld_i  (addr_ld_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .ptr_q      (ptr_q),
  .timeout_o  (timeout_o),
  .bus_stop_o (bus_stop_o),
  .cmd_valid_o(cmd_valid_o),
  .scratch_o  (scratch_o)
);

// File: tb/twi_reg_port_bench.sv
module twi_reg_port_bench;
  localparam int unsigned NP = 16, NI = 8, NS = 32, TO = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, stop = 1'b0, ald = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0, secret = 8'h5A, mac_rdata = 8'h00;
  logic [NP*8-1:0] prot = '0;
  logic [NI*8-1:0] id = '0;
  logic [7:0] rdata, mac_wdata, code, param;
  logic mac_rd, mac_wr, cmd_valid, tmo, bstop;
  logic [NS*8-1:0] scratch;
  logic [7:0] scr_m [NS];
  int errors = 0, checks = 0, cyc = 0;

  always #2.5 clk = ~clk;

  twi_reg_port #(.N_PAGES(NP), .ID_BYTES(NI), .SCR_BYTES(NS), .GRP_BYTES(4), .TIMEOUT_CYC(TO)) u_twi_reg_port (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .stop_i(stop), .addr_ld_i(ald), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .prot_i(prot), .secret_i(secret),
    .id_i(id), .mac_rdata_i(mac_rdata), .mac_rd_o(mac_rd), .mac_wr_o(mac_wr), .mac_wdata_o(mac_wdata),
    .cmd_valid_o(cmd_valid), .cmd_code_o(code), .cmd_param_o(param), .scratch_o(scratch),
    .timeout_o(tmo), .bus_stop_o(bstop));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=hung exp=done");
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask
  task automatic ld(input logic [7:0] a);
    ald = 1'b1; addr = a; tick(); ald = 1'b0;
  endtask
  task automatic wb(input logic [7:0] d);
    wr = 1'b1; wdata = d; tick(); wr = 1'b0;
  endtask
  task automatic rb(output logic [7:0] v);
    rd = 1'b1; tick(); rd = 1'b0; v = rdata;
  endtask
  task automatic do_stop();
    stop = 1'b1; tick(); stop = 1'b0;
  endtask

  function automatic logic [7:0] exp_prot(input int p);
    return prot[8*p +: 8];
  endfunction
  function automatic logic [7:0] exp_id(input int k);
    return id[8*k +: 8];
  endfunction
  function automatic logic [7:0] scr_byte(input int n);
    return scratch[8*n +: 8];
  endfunction

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < NS; i++) scr_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", 32'(rdata), 32'h00);
    chk("R1 scratch", 32'(|scratch), 32'h0);
    chk("R1 pulses", {29'b0, cmd_valid, tmo, bstop}, 32'h0);
    rb(v); chk("R1 first read at 00h", 32'(v), 32'h00);

    // R2 one group, R3 partial discarded at stop
    ld(8'h00);
    for (int i = 0; i < 4; i++) wb(8'hA0 + 8'(i));
    for (int i = 0; i < 3; i++) wb(8'hB0 + 8'(i));
    chk("R2 group committed", scratch[31:0], 32'hA3A2A1A0);
    chk("R3 partial pending", 32'(scr_byte(4)), 32'h00);
    do_stop();
    ld(8'h00);
    wb(8'hC0);
    chk("R3 partial dropped", 32'(scr_byte(4)), 32'h00);
    ld(8'h00);
    for (int i = 0; i < 5; i++) begin
      rb(v); chk("R2 readback", 32'(v), (i < 4) ? 32'hA0 + i : 32'h00);
    end
    for (int i = 0; i < 4; i++) scr_m[i] = 8'hA0 + 8'(i);

    // R4 access not starting at 00h
    ld(8'h04);
    for (int i = 0; i < 4; i++) wb(8'h55);
    chk("R4 write ignored", 32'(scr_byte(4)), 32'h00);
    ld(8'h01);
    rb(v); chk("R4 read FFh", 32'(v), 32'hFF);

    // R5 command pair, R6 MAC streaming
    ld(8'h40);
    wb(8'h33);
    chk("R5 no pulse after code", 32'(cmd_valid), 32'h0);
    wr = 1'b1; wdata = 8'h07; @(posedge clk); @(negedge clk); wr = 1'b0;
    chk("R5 pulse", 32'(cmd_valid), 32'h1);
    chk("R5 code/param", {16'h0, code, param}, 32'h3307);
    tick();
    chk("R5 pulse one cycle", 32'(cmd_valid), 32'h0);
    mac_rdata = 8'h9C;
    rd = 1'b1; #1;
    chk("R6 mac_rd strobe", 32'(mac_rd), 32'h1);
    tick(); rd = 1'b0;
    chk("R6 mac byte", 32'(rdata), 32'h9C);
    mac_rdata = 8'h3E;
    rb(v); chk("R6 pointer held", 32'(v), 32'h3E);
    wr = 1'b1; wdata = 8'h6B; #1;
    chk("R6 mac_wr", {23'h0, mac_wr, mac_wdata}, 32'h16B);
    tick(); wr = 1'b0;
    mac_rdata = 8'h11;
    rb(v); chk("R6 still at 41h", 32'(v), 32'h11);

    // R12 stop clears pending code
    ld(8'h40); wb(8'h21); do_stop();
    ld(8'h40); wb(8'h44); wb(8'h55); 
    chk("R12 stop cleared code", {16'h0, code, param}, 32'h4455);

    // R7, R8, R10 random reads
    for (int it = 0; it < 12; it++) begin
      int p, k;
      prot = {$urandom, $urandom, $urandom, $urandom};
      id = {$urandom, $urandom};
      secret = 8'($urandom);
      p = int'($urandom_range(NP - 1, 0));
      ld(8'h50 + 8'(p));
      rb(v); chk("R7 prot byte", 32'(v), 32'(exp_prot(p)));
      ld(8'h60);
      rb(v); chk("R7 secret", 32'(v), 32'(secret));
      ld(8'h67);
      rb(v); chk("R9 unmapped FFh", 32'(v), 32'hFF);
      for (k = 0; k < NI; k++) begin
        rb(v); chk("R8 R10 id byte", 32'(v), 32'(exp_id(k)));
      end
    end

    // R9 writes to read-only space
    ld(8'h50);
    wb(8'h11);
    chk("R9 no cmd", 32'(cmd_valid), 32'h0);
    rb(v); chk("R9 R10 next prot", 32'(v), 32'(exp_prot(1)));
    ld(8'h68); wb(8'h00); wb(8'h00);
    chk("R9 scratch kept", scratch[31:0], 32'hA3A2A1A0);
    ld(8'h20); rb(v); chk("R9 gap FFh", 32'(v), 32'hFF);
    ld(8'h40); rb(v); chk("R9 write-only FFh", 32'(v), 32'hFF);

    // R2 R3 random group writes
    for (int it = 0; it < 20; it++) begin
      int ng, extra;
      ng = int'($urandom_range(8, 1));
      extra = int'($urandom_range(3, 0));
      ld(8'h00);
      for (int i = 0; i < 4 * ng + extra; i++) begin
        logic [7:0] d;
        d = 8'($urandom);
        wb(d);
        if (i < 4 * ng) scr_m[i] = d;
      end
      if (it[0]) do_stop();
      ld(8'h00);
      for (int i = 0; i < NS; i++) begin
        rb(v); chk("R2 R3 random readback", 32'(v), 32'(scr_m[i]));
      end
    end

    // R11 timeout timing
    scl = 1'b0;
    for (int e = 1; e <= TO + 1; e++) begin
      tick();
      if (e == TO - 1) chk("R11 not yet", 32'(tmo), 32'h0);
      if (e == TO) chk("R11 expiry", {30'h0, tmo, bstop}, 32'h3);
      if (e == TO + 1) chk("R11 single pulse", 32'(tmo), 32'h0);
    end
    repeat (3 * TO) begin
      tick();
      if (tmo) chk("R11 no repeat", 32'(tmo), 32'h0);
    end
    scl = 1'b1; tick();
    begin
      int seen = 0;
      for (int r = 0; r < 3; r++) begin
        scl = 1'b0;
        repeat (TO - 2) begin tick(); seen += int'(tmo); end
        scl = 1'b1; tick(); seen += int'(tmo);
      end
      chk("R11 restart on high", 32'(seen), 32'h0);
    end

    // R12 timeout acts as stop
    ld(8'h00); wb(8'hE0); wb(8'hE1);
    scl = 1'b0;
    repeat (TO) tick();
    scl = 1'b1; tick();
    wb(8'hE2); wb(8'hE3);
    chk("R12 timeout drops group", 32'(scr_byte(0)), 32'(scr_m[0]));
    rd = 1'b1; tick(); rd = 1'b0;
    chk("R12 access removed", 32'(rdata), 32'hFF);

    summary();
  end
endmodule